// File: doc/BRIEF.md
# Oscillator Divider Chain With Rate Select

This block sits between the oscillator strobe of a timekeeping device and the logic that consumes timing events. A strobe arrives once per half-period of the 32768 Hz oscillator. A phase flop rebuilds the 32 kHz level from these strobes, and a 15-stage binary divider counts full oscillator periods. A three-bit control field selects one of three oscillator states: stopped, running with the divider counting, or running with the divider held at zero.

A four-bit rate code picks one divider stage through a single 16-way multiplexer. That one selected level drives both the periodic event pulse and the square-wave pin. The square-wave pin has an enable bit. An override bit places the raw 32 kHz level on the pin whatever the rate code says. When the last stage wraps, the block emits a one-second tick.

Top module: `rate_divider`

## Requirements
- R1: While reset is high and in the first cycle after it falls with the controls at zero, the oscillator is stopped, the divider count and phase are zero, and `sqw_out`, `periodic_pulse`, `sec_tick` and `osc_running` are all low.
- R2: Control bits [2:1] = 01 mean running with the divider counting, and 11 means running with the divider forced to zero. The values 00 and 10 mean stopped. Bit 0 is ignored. `osc_running` is high exactly in the two running states.
- R3: While stopped, strobes have no effect: the 32 kHz phase and the divider count keep their values, and this can be seen on `sqw_out` with the override set.
- R4: While running, in either state, each strobe toggles the 32 kHz phase. The divider advances by one only in the counting state, on a strobe that takes the phase from 1 to 0. With `sqw_en` and `fast_ovr` both high, `sqw_out` shows the phase.
- R5: Stage k of the divider (count bit k, k = 0..14) runs at 32768/2^(k+1) Hz. Rate code 1 selects stage 6 (256 Hz), code 2 selects stage 7 (128 Hz), and a code c of 3 or more selects stage c-2 (8192 Hz down to 2 Hz).
- R6: `periodic_pulse` is high for exactly one cycle after each edge on which the selected stage level goes from 0 to 1.
- R7: `sqw_out` is low when `sqw_en` is low. With `sqw_en` high and `fast_ovr` low, it follows the selected stage level.
- R8: Rate code 0 selects no stage: `periodic_pulse` stays low, and `sqw_out` is low unless the override is active.
- R9: `sec_tick` is high for one cycle right after the divider wraps from all ones to zero. This happens once every 32768 counted oscillator periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_strobe | input | 1 | One pulse per oscillator half-period |
| osc_ctl | input | 3 | Oscillator state control (bits [2:1] decoded, bit 0 ignored) |
| rate_code | input | 4 | Divider stage select for the pulse and the pin |
| sqw_en | input | 1 | Square-wave pin enable |
| fast_ovr | input | 1 | Put the raw 32 kHz level on the pin |
| sqw_out | output | 1 | Square-wave pin level |
| periodic_pulse | output | 1 | One-cycle pulse on each rising edge of the selected stage |
| sec_tick | output | 1 | One-cycle pulse when the last stage wraps |
| osc_running | output | 1 | High while the oscillator runs |

## Verification
The bench builds the block with its default of 15 divider stages and a 4-bit rate code, and drives a strobe in most cycles. A full 32768-period wrap therefore fits in about 65,000 clock cycles, so the one-second tick is observed directly rather than inferred. The random segments move between the stopped, counting and held states and sweep every rate code, with the override set and cleared. Directed runs count the pulses at the two low rate codes and at several high ones, so the tap mapping is checked against measured periods.

// File: rtl/ratediv_pkg.sv
package ratediv_pkg;

    localparam int DIV_STAGES = 15;
    localparam int RATE_W     = 4;
    localparam int LOW_TAP_A  = 6;
    localparam int LOW_TAP_B  = 7;
    localparam int MAIN_SHIFT = 2;

    typedef enum logic [1:0] {
        OSC_STOP  = 2'd0,
        OSC_COUNT = 2'd1,
        OSC_HELD  = 2'd2
    } osc_mode_e;

    typedef struct packed {
        logic phase;
        logic advance;
        logic hold;
    } osc_status_t;

    function automatic osc_mode_e decode_mode(input logic [1:0] sel);
        case (sel)
            2'b01:   return OSC_COUNT;
            2'b11:   return OSC_HELD;
            default: return OSC_STOP;
        endcase
    endfunction

    function automatic int stage_of_code(input int code);
        if (code == 0) return 0;
        if (code == 1) return LOW_TAP_A;
        if (code == 2) return LOW_TAP_B;
        return code - MAIN_SHIFT;
    endfunction

endpackage

// File: rtl/osc_gate.sv
module osc_gate
    import ratediv_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        strobe,
    input  logic [1:0]  mode_bits,
    output osc_mode_e   mode,
    output osc_status_t stat
);
    logic phase_q;

    assign mode = decode_mode(mode_bits);

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= 1'b0;
        else if (mode != OSC_STOP && strobe)
            phase_q <= ~phase_q;
    end

    always_comb begin
        stat.phase   = phase_q;
        stat.hold    = (mode == OSC_HELD);
        stat.advance = (mode == OSC_COUNT) && strobe && phase_q;
    end

    // R4: a running oscillator flips phase on every strobe
    a_r4_phase_toggle: assert property (@(posedge clk) disable iff (rst)
        (mode != OSC_STOP && strobe) |=> (phase_q != $past(phase_q)));

    // R3: a stopped oscillator keeps its phase
    a_r3_phase_frozen: assert property (@(posedge clk) disable iff (rst)
        (mode == OSC_STOP) |=> $stable(phase_q));
endmodule

// File: rtl/div_chain.sv
module div_chain #(
    parameter int STAGES = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    input  logic              hold,
    output logic [STAGES-1:0] count,
    output logic              wrap_q
);
    logic [STAGES:0] stage_en;

    assign stage_en[0] = advance;

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            assign stage_en[i+1] = stage_en[i] & count[i];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || hold)
            count <= '0;
        else
            count <= count ^ stage_en[STAGES-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            wrap_q <= 1'b0;
        else
            wrap_q <= stage_en[STAGES] & ~hold;
    end

    // R2: the held state forces the chain to zero
    a_r2_hold_clears: assert property (@(posedge clk) disable iff (rst)
        hold |=> (count == '0));

    // R3: without an advance the count does not move
    a_r3_count_frozen: assert property (@(posedge clk) disable iff (rst)
        (!advance && !hold) |=> $stable(count));

    // R9: the wrap tick coincides with a zero count
    a_r9_wrap_zero: assert property (@(posedge clk) disable iff (rst)
        wrap_q |-> (count == '0));
endmodule

// File: rtl/tap_select.sv
module tap_select
    import ratediv_pkg::*;
#(
    parameter int STAGES = 15,
    parameter int SEL_W  = 4
) (
    input  logic [STAGES-1:0] count,
    input  logic [SEL_W-1:0]  code,
    output logic              level
);
    localparam int NUM_CODES = 2 ** SEL_W;

    logic [NUM_CODES-1:0] cand;

    genvar g;
    generate
        for (g = 0; g < NUM_CODES; g++) begin : g_code
            localparam int IDX = stage_of_code(g);
            if (g == 0) begin : g_none
                assign cand[g] = 1'b0;
            end else begin : g_tap
                assign cand[g] = count[IDX];
            end
        end
    endgenerate

    assign level = cand[code];
endmodule

// File: rtl/rate_divider.sv
module rate_divider
    import ratediv_pkg::*;
#(
    parameter int STAGES = DIV_STAGES,
    parameter int SEL_W  = RATE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             osc_strobe,
    input  logic [2:0]       osc_ctl,
    input  logic [SEL_W-1:0] rate_code,
    input  logic             sqw_en,
    input  logic             fast_ovr,
    output logic             sqw_out,
    output logic             periodic_pulse,
    output logic             sec_tick,
    output logic             osc_running
);
    osc_mode_e         mode;
    osc_status_t       stat;
    logic [STAGES-1:0] count;
    logic              tap_now;
    logic              tap_q;
    logic              wrap_q;
    logic              unused_ctl;

    assign unused_ctl = osc_ctl[0];

    osc_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .strobe    (osc_strobe),
        .mode_bits (osc_ctl[2:1]),
        .mode      (mode),
        .stat      (stat)
    );

    div_chain #(.STAGES(STAGES)) u_chain (
        .clk     (clk),
        .rst     (rst),
        .advance (stat.advance),
        .hold    (stat.hold),
        .count   (count),
        .wrap_q  (wrap_q)
    );

    tap_select #(.STAGES(STAGES), .SEL_W(SEL_W)) u_tap (
        .count (count),
        .code  (rate_code),
        .level (tap_now)
    );

    always_ff @(posedge clk) begin
        if (rst)
            tap_q <= 1'b0;
        else
            tap_q <= tap_now;
    end

    always_comb begin
        periodic_pulse = tap_now & ~tap_q;
        sec_tick       = wrap_q;
        osc_running    = (mode != OSC_STOP);
        if (!sqw_en)
            sqw_out = 1'b0;
        else if (fast_ovr)
            sqw_out = stat.phase;
        else
            sqw_out = tap_now;
    end

    // R6: an event pulse never lasts two cycles
    a_r6_pulse_single: assert property (@(posedge clk) disable iff (rst)
        periodic_pulse |=> !periodic_pulse);

    // R8: rate code zero yields neither pulses nor a divided pin level
    a_r8_idle_code: assert property (@(posedge clk) disable iff (rst)
        (rate_code == '0) |-> (!periodic_pulse && (!sqw_out || fast_ovr)));

    // R9: the second tick is a single-cycle pulse
    a_r9_tick_single: assert property (@(posedge clk) disable iff (rst)
        sec_tick |=> !sec_tick);
endmodule

// File: tb/rate_divider_test.sv
`timescale 1ns/1ps
module rate_divider_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       strobe = 1'b0;
    logic [2:0] ctl = 3'b000;
    logic [3:0] rate = 4'd0;
    logic       en = 1'b0;
    logic       ovr = 1'b0;
    logic       sqw_out, periodic_pulse, sec_tick, osc_running;

    always #2.5 clk = ~clk;

    rate_divider uut (
        .clk(clk), .rst(rst), .osc_strobe(strobe), .osc_ctl(ctl),
        .rate_code(rate), .sqw_en(en), .fast_ovr(ovr),
        .sqw_out(sqw_out), .periodic_pulse(periodic_pulse),
        .sec_tick(sec_tick), .osc_running(osc_running)
    );

    logic        m_phase = 1'b0;
    logic [14:0] m_cnt = '0;
    logic        m_tapq = 1'b0;
    logic        m_sec = 1'b0;
    int          checks = 0;
    int          fails = 0;
    int          pulse_seen = 0;
    int          sec_seen = 0;
    bit          done = 1'b0;

    function automatic logic sel_tap(input logic [14:0] c, input logic [3:0] r);
        if (r == 4'd0) return 1'b0;
        if (r == 4'd1) return c[6];
        if (r == 4'd2) return c[7];
        return c[r - 4'd2];
    endfunction

    function automatic int mode_of(input logic [2:0] c);
        if (c[2:1] == 2'b01) return 1;
        if (c[2:1] == 2'b11) return 2;
        return 0;
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        int  md;
        logic adv;
        md = mode_of(ctl);
        if (rst) begin
            m_phase = 1'b0; m_cnt = '0; m_tapq = 1'b0; m_sec = 1'b0;
        end else begin
            adv    = (md == 1) && strobe && m_phase;
            m_tapq = sel_tap(m_cnt, rate);
            m_sec  = adv && (m_cnt == 15'h7fff);
            if (md != 0 && strobe) m_phase = ~m_phase;
            if (md == 2) m_cnt = '0;
            else if (adv) m_cnt = m_cnt + 15'd1;
        end
    endtask

    task automatic compare();
        logic t;
        int   md;
        md = mode_of(ctl);
        t  = sel_tap(m_cnt, rate);
        chk(md == 0 ? "R3 sqw" : ((en && ovr) ? "R4 sqw" : (rate == 0 ? "R8 sqw" : "R7 sqw")),
            sqw_out, en ? (ovr ? m_phase : t) : 1'b0);
        chk(rate == 0 ? "R8 pulse" : "R6 pulse", periodic_pulse, t & ~m_tapq);
        chk("R9 sec_tick", sec_tick, m_sec);
        chk("R2 osc_running", osc_running, md != 0);
        pulse_seen += int'(periodic_pulse);
        sec_seen   += int'(sec_tick);
    endtask

    task automatic step(input logic [2:0] c, input logic s, input logic [3:0] r,
                        input logic e, input logic o);
        @(posedge clk);
        model_edge();
        #1;
        ctl = c; strobe = s; rate = r; en = e; ovr = o;
        #1;
        compare();
    endtask

    task automatic measure(input logic [3:0] code, input int stage, input int periods);
        int n;
        n = (4 << stage) * periods;
        repeat (4) step(3'b110, 1'b1, code, 1'b1, 1'b0);
        pulse_seen = 0;
        for (int k = 0; k < n; k++) step(3'b010, 1'b1, code, 1'b1, 1'b0);
        checks++;
        if (pulse_seen < periods - 1 || pulse_seen > periods + 1) begin
            fails++;
            $display("FAIL R5 code %0d: actual=%0d pulses expected=%0d", code, pulse_seen, periods);
        end
    endtask

    initial begin
        void'($urandom(32'h1a2b3c4d));
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs quiet during reset
        chk("R1 sqw", sqw_out, 1'b0);
        chk("R1 pulse", periodic_pulse, 1'b0);
        chk("R1 sec", sec_tick, 1'b0);
        chk("R1 running", osc_running, 1'b0);
        @(posedge clk);
        model_edge();
        #1;
        rst = 1'b0;
        step(3'b000, 1'b0, 4'd0, 1'b1, 1'b1);
        chk("R1 phase zero", sqw_out, 1'b0);

        // R3: stopped with strobes, phase visible through the override
        for (int k = 0; k < 20; k++) step(3'b101, 1'b1, 4'd3, 1'b1, 1'b1);
        // R4: running, phase toggles on the pin
        for (int k = 0; k < 20; k++) step(3'b011, 1'b1, 4'd3, 1'b1, 1'b1);
        // R3: stop again mid-count, nothing may move
        for (int k = 0; k < 20; k++) step(3'b000, 1'b1, 4'd3, 1'b1, 1'b0);

        // R5: measured pulse rates for a spread of codes
        measure(4'd1, 6, 10);
        measure(4'd2, 7, 10);
        measure(4'd3, 1, 40);
        measure(4'd4, 2, 40);
        measure(4'd9, 7, 8);

        // random segments over every state, code and pin setting
        for (int seg = 0; seg < 500; seg++) begin
            logic [2:0] c;
            logic [3:0] r;
            logic e, o;
            int pick;
            pick = $urandom_range(0, 9);
            c = (pick < 6) ? {2'b01, 1'($urandom)} :
                (pick < 8) ? {2'b11, 1'($urandom)} : {1'($urandom), 1'b0, 1'($urandom)};
            r = 4'($urandom);
            e = ($urandom_range(0, 3) != 0);
            o = ($urandom_range(0, 3) == 0);
            for (int k = 0; k < 60; k++)
                step(c, $urandom_range(0, 9) < 7, r, e, o);
        end

        // R9: a full wrap of the chain from zero
        repeat (4) step(3'b110, 1'b1, 4'd15, 1'b1, 1'b0);
        sec_seen = 0;
        for (int k = 0; k < 65536 + 40; k++) step(3'b010, 1'b1, 4'd15, 1'b1, 1'b0);
        checks++;
        if (sec_seen != 1) begin
            fails++;
            $display("FAIL R9 wrap count: actual=%0d expected=1", sec_seen);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule